// File: doc/BRIEF.md
# Sixteen-Pin GPIO with Masked Output Writes and a Shared Interrupt

This block drives and senses sixteen general-purpose pins for a register bus. Software sets each pin's direction, updates driven levels, reads back synchronised pin levels, and picks which of the upper eight pins take part in a single shared interrupt line. A write to the output register carries a per-bit write mask in its upper half-word. A driver can therefore change one pin without a read-modify-write sequence, and cannot disturb pins owned by other code.

A control register gates the whole block. One bit enables the clock and another holds the block in soft reset. Until software enables the clock and releases the soft reset, every pin register stays at zero and writes to it have no effect. The control register itself can always be written. The lower eight pins each raise their own level interrupt request. The upper eight pins are each ANDed with an enable bit, and the results are ORed into one active-high level line for an external interrupt controller.

Top module: `gpmask_gpio`

## Requirements
- R1: While rst_n is low, on the next rising edge the block clears every register. pin_oe, pin_out, irq_pin, irq_shared and bus_rdata are then 0, and the control register reads 0.
- R2: The control register is at byte offset 0x14. Bit 0 enables the clock and bit 1 asserts soft reset. It reads back in bits 1:0 and can be written at any time. The block is active only when the register holds bit0=1 and bit1=0.
- R3: While the block is inactive, writes to the direction, output and interrupt-enable registers are ignored. One edge after the block becomes inactive, those registers are 0 and so is the synchronised pin state. They read as 0 and pin_oe, pin_out, irq_pin and irq_shared are 0.
- R4: The direction register is at offset 0x00. Bit n = 1 makes pin n an output (pin_oe[n] = 1) and 0 makes it an input. A write appears on pin_oe after the write edge, and the value reads back in bits 15:0.
- R5: The output register is at offset 0x08. A write updates output bit n only when written bit n+16 is 1, and the new value is taken from written bit n. pin_out shows the latched value.
- R6: Reading offset 0x08 returns the latched output bits in bits 15:0 and 0 in bits 31:16.
- R7: Reading offset 0x0C returns the pin levels through a two-flop synchroniser in bits 15:0. A level change reaches the synchronised state, and so irq_pin and irq_shared, on the second rising edge after it.
- R8: The interrupt-enable register is at offset 0x10 and holds 8 bits. Bit k enables pin 8+k. Written bits above 7 are dropped and read back as 0.
- R9: irq_shared is high exactly while some synchronised pin 8+k is high with enable bit k set. It is level-sensitive and falls when the source falls.
- R10: irq_pin[k] for k = 0..7 follows synchronised pin k whatever the interrupt-enable register holds.
- R11: bus_rdata is loaded on the edge that samples a read (bus_sel=1, bus_wr=0) and holds otherwise. Unmapped offsets read 0 and ignore writes.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| bus_sel | input | 1 | Bus access strobe, one cycle per access |
| bus_wr | input | 1 | 1 = write, 0 = read |
| bus_addr | input | 8 | Byte offset of the register |
| bus_wdata | input | 32 | Write data |
| bus_rdata | output | 32 | Read data, valid the cycle after a read |
| pin_in | input | 16 | Pin levels from the pads |
| pin_oe | output | 16 | Per-pin output enable |
| pin_out | output | 16 | Per-pin driven level |
| irq_pin | output | 8 | Individual level requests of pins 0..7 |
| irq_shared | output | 1 | Shared AND-OR request of pins 8..15 |

## Verification
Register writes show on pin_oe and pin_out right after the write edge, so the bench checks those ports at the falling edge that follows the write. Read data arrives one edge after the read is sampled. The driver queues each expected word, and a monitor compares it at the next falling edge only when a read was captured. Pin changes need two edges before pin state and interrupts follow. The bench checks irq_pin after one edge, where it must still hold the old value, and again after the second, where it must hold the new one. Re-entering soft reset takes one further edge to clear the registers, and the bench waits out that edge before it checks.

// File: rtl/gpmask_pkg.sv
// Package: register offsets and control-bit positions shared by the GPIO block.
// Assumes byte offsets fit in eight bits.
package gpmask_pkg;
    localparam logic [7:0] OFS_DIR  = 8'h00;
    localparam logic [7:0] OFS_OUT  = 8'h08;
    localparam logic [7:0] OFS_PIN  = 8'h0C;
    localparam logic [7:0] OFS_IEN  = 8'h10;
    localparam logic [7:0] OFS_CTL  = 8'h14;

    localparam int CTL_CLKEN = 0;
    localparam int CTL_SRST  = 1;

    typedef enum logic [2:0] {
        SEL_NONE,
        SEL_DIR,
        SEL_OUT,
        SEL_PIN,
        SEL_IEN,
        SEL_CTL
    } reg_sel_e;
endpackage

// File: rtl/gpmask_sync.sv
// Module: multi-stage synchroniser for the pin inputs.
// Assumes the inputs are asynchronous levels. clr empties the chain
// synchronously, as a gated clock would leave it.
module gpmask_sync #(
    parameter int W      = 16,
    parameter int STAGES = 2
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic         clr,
    input  logic [W-1:0] d,
    output logic [W-1:0] q
);
    logic [W-1:0] stg_q [STAGES];

    // Shift the pin levels through the stage chain.
    always_ff @(posedge clk) begin
        if (!rst_n || clr) begin
            for (int i = 0; i < STAGES; i++) stg_q[i] <= '0;
        end else begin
            stg_q[0] <= d;
            for (int i = 1; i < STAGES; i++) stg_q[i] <= stg_q[i-1];
        end
    end

    assign q = stg_q[STAGES-1];
endmodule

// File: rtl/gpmask_regs.sv
// Module: register file. It holds control, direction, masked output and
// interrupt enable, and returns read data.
// Assumes DW >= 2*NPIN so the output write mask fits in the upper half-word.
module gpmask_regs
    import gpmask_pkg::*;
#(
    parameter int NPIN = 16,
    parameter int NSHR = 8,
    parameter int AW   = 8,
    parameter int DW   = 32
) (
    input  logic            clk,
    input  logic            rst_n,
    input  logic            bus_sel,
    input  logic            bus_wr,
    input  logic [AW-1:0]   bus_addr,
    input  logic [DW-1:0]   bus_wdata,
    input  logic [NPIN-1:0] pin_sync,
    output logic [DW-1:0]   bus_rdata,
    output logic [NPIN-1:0] dir_q,
    output logic [NPIN-1:0] out_q,
    output logic [NSHR-1:0] ien_q,
    output logic            active
);
    logic [1:0]      ctrl_q;
    reg_sel_e        sel;
    logic            wr_en;
    logic [NPIN-1:0] wmask;
    logic [DW-1:0]   rd_next;

    // Decode the byte offset into a register select.
    always_comb begin
        if      (bus_addr == AW'(OFS_DIR)) sel = SEL_DIR;
        else if (bus_addr == AW'(OFS_OUT)) sel = SEL_OUT;
        else if (bus_addr == AW'(OFS_PIN)) sel = SEL_PIN;
        else if (bus_addr == AW'(OFS_IEN)) sel = SEL_IEN;
        else if (bus_addr == AW'(OFS_CTL)) sel = SEL_CTL;
        else                               sel = SEL_NONE;
    end

    assign active = ctrl_q[CTL_CLKEN] & ~ctrl_q[CTL_SRST];
    assign wr_en  = bus_sel & bus_wr;
    assign wmask  = bus_wdata[NPIN +: NPIN];

    // Control register: always writable, independent of the gating it drives.
    always_ff @(posedge clk) begin
        if (!rst_n)                          ctrl_q <= '0;
        else if (wr_en && sel == SEL_CTL)    ctrl_q <= bus_wdata[1:0];
    end

    // Pin registers: cleared while inactive, otherwise loaded by writes.
    always_ff @(posedge clk) begin
        if (!rst_n || !active) begin
            dir_q <= '0;
            out_q <= '0;
            ien_q <= '0;
        end else if (wr_en) begin
            case (sel)
                SEL_DIR: dir_q <= bus_wdata[NPIN-1:0];
                SEL_OUT: out_q <= (out_q & ~wmask) | (bus_wdata[NPIN-1:0] & wmask);
                SEL_IEN: ien_q <= bus_wdata[NSHR-1:0];
                default: ;
            endcase
        end
    end

    // Read multiplexer: zero-extended register contents.
    always_comb begin
        rd_next = '0;
        case (sel)
            SEL_DIR: rd_next[NPIN-1:0] = dir_q;
            SEL_OUT: rd_next[NPIN-1:0] = out_q;
            SEL_PIN: rd_next[NPIN-1:0] = pin_sync;
            SEL_IEN: rd_next[NSHR-1:0] = ien_q;
            SEL_CTL: rd_next[1:0]      = ctrl_q;
            default: ;
        endcase
    end

    // Read data register: loads on a read, holds otherwise.
    always_ff @(posedge clk) begin
        if (!rst_n)                 bus_rdata <= '0;
        else if (bus_sel && !bus_wr) bus_rdata <= rd_next;
    end
endmodule

// File: rtl/gpmask_irq.sv
// Module: interrupt formation. The lower pins pass through as individual
// requests. The upper NSHR pins are ANDed with enables and ORed into one line.
// Assumes synchronised, level-sensitive sources.
module gpmask_irq #(
    parameter int NPIN = 16,
    parameter int NSHR = 8,
    localparam int NDED = NPIN - NSHR
) (
    input  logic            active,
    input  logic [NPIN-1:0] pin_sync,
    input  logic [NSHR-1:0] ien_q,
    output logic [NDED-1:0] irq_pin,
    output logic            irq_shared
);
    logic [NSHR-1:0] term;

    // One gated term per shared pin.
    for (genvar k = 0; k < NSHR; k++) begin : g_term
        assign term[k] = pin_sync[NDED + k] & ien_q[k];
    end

    assign irq_shared = active & (|term);
    assign irq_pin    = active ? pin_sync[NDED-1:0] : '0;
endmodule

// File: rtl/gpmask_gpio.sv
// Module: top of the masked-write GPIO. It joins the register file, the
// pin synchroniser and the interrupt formation.
// Assumes single-cycle bus accesses and synchronous active-low reset.
module gpmask_gpio #(
    parameter int NPIN   = 16,
    parameter int NSHR   = 8,
    parameter int AW     = 8,
    parameter int DW     = 32,
    parameter int STAGES = 2,
    localparam int NDED  = NPIN - NSHR
) (
    input  logic            clk,
    input  logic            rst_n,
    input  logic            bus_sel,
    input  logic            bus_wr,
    input  logic [AW-1:0]   bus_addr,
    input  logic [DW-1:0]   bus_wdata,
    output logic [DW-1:0]   bus_rdata,
    input  logic [NPIN-1:0] pin_in,
    output logic [NPIN-1:0] pin_oe,
    output logic [NPIN-1:0] pin_out,
    output logic [NDED-1:0] irq_pin,
    output logic            irq_shared
);
    logic [NPIN-1:0] pin_sync;
    logic [NPIN-1:0] dir_q;
    logic [NPIN-1:0] out_q;
    logic [NSHR-1:0] ien_q;
    logic            active;

    gpmask_sync #(.W(NPIN), .STAGES(STAGES)) u_sync (
        .clk   (clk),
        .rst_n (rst_n),
        .clr   (~active),
        .d     (pin_in),
        .q     (pin_sync)
    );

    gpmask_regs #(.NPIN(NPIN), .NSHR(NSHR), .AW(AW), .DW(DW)) u_regs (
        .clk       (clk),
        .rst_n     (rst_n),
        .bus_sel   (bus_sel),
        .bus_wr    (bus_wr),
        .bus_addr  (bus_addr),
        .bus_wdata (bus_wdata),
        .pin_sync  (pin_sync),
        .bus_rdata (bus_rdata),
        .dir_q     (dir_q),
        .out_q     (out_q),
        .ien_q     (ien_q),
        .active    (active)
    );

    gpmask_irq #(.NPIN(NPIN), .NSHR(NSHR)) u_irq (
        .active     (active),
        .pin_sync   (pin_sync),
        .ien_q      (ien_q),
        .irq_pin    (irq_pin),
        .irq_shared (irq_shared)
    );

    assign pin_oe  = dir_q;
    assign pin_out = out_q;
endmodule

// File: rtl/gpmask_gpio_chk.sv
// Module: assertion checker bound to gpmask_gpio.
// Assumes the bound top's internal names active, ien_q and pin_sync.
module gpmask_gpio_chk
    import gpmask_pkg::*;
#(
    parameter int NPIN = 16,
    parameter int NSHR = 8,
    parameter int AW   = 8,
    parameter int DW   = 32,
    localparam int NDED = NPIN - NSHR
) (
    input logic            clk,
    input logic            rst_n,
    input logic            bus_sel,
    input logic            bus_wr,
    input logic [AW-1:0]   bus_addr,
    input logic [DW-1:0]   bus_wdata,
    input logic [DW-1:0]   bus_rdata,
    input logic [NPIN-1:0] pin_oe,
    input logic [NPIN-1:0] pin_out,
    input logic [NDED-1:0] irq_pin,
    input logic            irq_shared,
    input logic            active,
    input logic [NSHR-1:0] ien_q,
    input logic [NPIN-1:0] pin_sync
);
    logic wr_dir, wr_out;
    assign wr_dir = bus_sel && bus_wr && bus_addr == AW'(OFS_DIR);
    assign wr_out = bus_sel && bus_wr && bus_addr == AW'(OFS_OUT);

    AST_RESET_IDLE: assert property (@(posedge clk)
        !rst_n |=> (pin_oe == '0 && pin_out == '0 && irq_shared == 1'b0 && bus_rdata == '0)); // R1

    AST_INACTIVE_QUIET: assert property (@(posedge clk) disable iff (!rst_n)
        !active |=> (pin_oe == '0 && pin_out == '0 && irq_pin == '0 && irq_shared == 1'b0)); // R3

    AST_OE_FOLLOWS_DIR: assert property (@(posedge clk) disable iff (!rst_n)
        (active && wr_dir) |=> pin_oe == $past(bus_wdata[NPIN-1:0])); // R4

    AST_MASK_KEEPS_BITS: assert property (@(posedge clk) disable iff (!rst_n)
        (active && wr_out) |=> ((pin_out ^ $past(pin_out)) & ~$past(bus_wdata[NPIN +: NPIN])) == '0); // R5

    AST_SHARED_NEEDS_EN: assert property (@(posedge clk) disable iff (!rst_n)
        irq_shared |-> ien_q != '0); // R9

    AST_SHARED_NEEDS_SRC: assert property (@(posedge clk) disable iff (!rst_n)
        irq_shared |-> pin_sync[NPIN-1:NDED] != '0); // R9

    AST_RDATA_HOLDS: assert property (@(posedge clk) disable iff (!rst_n)
        !(bus_sel && !bus_wr) |=> $stable(bus_rdata)); // R11
endmodule

bind gpmask_gpio gpmask_gpio_chk #(.NPIN(NPIN), .NSHR(NSHR), .AW(AW), .DW(DW)) u_chk (
    .clk        (clk),
    .rst_n      (rst_n),
    .bus_sel    (bus_sel),
    .bus_wr     (bus_wr),
    .bus_addr   (bus_addr),
    .bus_wdata  (bus_wdata),
    .bus_rdata  (bus_rdata),
    .pin_oe     (pin_oe),
    .pin_out    (pin_out),
    .irq_pin    (irq_pin),
    .irq_shared (irq_shared),
    .active     (active),
    .ien_q      (ien_q),
    .pin_sync   (pin_sync)
);

// File: tb/gpmask_gpio_tb.sv
// Scoreboard bench: bus tasks queue expected read data, and a monitor pops
// and compares each word the cycle the design returns it.
module gpmask_gpio_tb;
    localparam int CLK_PERIOD = 10;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        bus_sel = 1'b0;
    logic        bus_wr = 1'b0;
    logic [7:0]  bus_addr = '0;
    logic [31:0] bus_wdata = '0;
    logic [31:0] bus_rdata;
    logic [15:0] pin_in = '0;
    logic [15:0] pin_oe;
    logic [15:0] pin_out;
    logic [7:0]  irq_pin;
    logic        irq_shared;

    int n_vec = 0;
    int n_bad = 0;
    bit done  = 1'b0;
    logic rd_seen = 1'b0;
    logic [31:0] exp_q[$];
    string       tag_q[$];

    always #(CLK_PERIOD/2) clk = ~clk;

    gpmask_gpio u_dut (
        .clk(clk), .rst_n(rst_n), .bus_sel(bus_sel), .bus_wr(bus_wr),
        .bus_addr(bus_addr), .bus_wdata(bus_wdata), .bus_rdata(bus_rdata),
        .pin_in(pin_in), .pin_oe(pin_oe), .pin_out(pin_out),
        .irq_pin(irq_pin), .irq_shared(irq_shared)
    );

    task automatic chk(string tag, logic [31:0] act, logic [31:0] exp);
        n_vec++;
        if (act !== exp) begin
            n_bad++;
            $display("FAIL %s: actual %h expected %h", tag, act, exp);
        end
    endtask

    task automatic finish_run();
        if (!done) begin
            done = 1'b1;
            $display("== %0d vectors applied, %0d miscompares ==", n_vec, n_bad);
            $finish;
        end
    endtask

    // Note which edges captured a read.
    always @(posedge clk) rd_seen <= bus_sel & ~bus_wr;

    // Monitor: compare returned read data against the queue head.
    always @(negedge clk) begin
        if (rd_seen) begin
            if (exp_q.size() == 0) chk("R11 unexpected read data", bus_rdata, 32'hx);
            else chk(tag_q.pop_front(), bus_rdata, exp_q.pop_front());
        end
    end

    task automatic bus_write(logic [7:0] a, logic [31:0] d);
        @(negedge clk);
        bus_sel = 1'b1; bus_wr = 1'b1; bus_addr = a; bus_wdata = d;
        @(negedge clk);
        bus_sel = 1'b0; bus_wr = 1'b0;
    endtask

    task automatic bus_read(logic [7:0] a, logic [31:0] exp, string tag);
        @(negedge clk);
        exp_q.push_back(exp); tag_q.push_back(tag);
        bus_sel = 1'b1; bus_wr = 1'b0; bus_addr = a;
        @(negedge clk);
        bus_sel = 1'b0;
    endtask

    task automatic set_pins(logic [15:0] v);
        @(negedge clk);
        pin_in = v;
        repeat (2) @(negedge clk);
    endtask

    initial begin
        #(CLK_PERIOD * 200000);
        n_vec++; n_bad++;
        $display("FAIL watchdog: actual running expected finished");
        finish_run();
    end

    initial begin
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        // R1 reset state
        chk("R1 pin_oe", {16'h0, pin_oe}, 32'h0);
        chk("R1 pin_out", {16'h0, pin_out}, 32'h0);
        chk("R1 irq", {23'h0, irq_shared, irq_pin}, 32'h0);
        chk("R1 rdata", bus_rdata, 32'h0);
        bus_read(8'h14, 32'h0, "R1 ctrl");

        // R3 writes ignored while clock disabled
        bus_write(8'h00, 32'h0000_FFFF);
        chk("R3 oe inactive", {16'h0, pin_oe}, 32'h0);
        bus_write(8'h08, 32'hFFFF_FFFF);
        chk("R3 out inactive", {16'h0, pin_out}, 32'h0);
        bus_read(8'h00, 32'h0, "R3 dir inactive");

        // R2 reset+clock, then clock only
        bus_write(8'h14, 32'h3);
        bus_read(8'h14, 32'h3, "R2 ctrl 3");
        bus_write(8'h00, 32'h0000_00FF);
        chk("R3 oe in soft reset", {16'h0, pin_oe}, 32'h0);
        bus_write(8'h14, 32'h1);
        bus_read(8'h14, 32'h1, "R2 ctrl 1");

        // R4 direction
        bus_write(8'h00, 32'h0000_A55A);
        chk("R4 pin_oe", {16'h0, pin_oe}, 32'h0000_A55A);
        bus_read(8'h00, 32'h0000_A55A, "R4 dir read");

        // R5 masked output, R6 readback
        bus_write(8'h08, 32'hFFFF_FFFF);
        chk("R5 all set", {16'h0, pin_out}, 32'h0000_FFFF);
        bus_write(8'h08, 32'h00F0_0000);
        chk("R5 clear 7:4", {16'h0, pin_out}, 32'h0000_FF0F);
        bus_write(8'h08, 32'h0003_0002);
        chk("R5 bits 1:0", {16'h0, pin_out}, 32'h0000_FF0E);
        bus_write(8'h08, 32'h0000_FFFF);
        chk("R5 empty mask", {16'h0, pin_out}, 32'h0000_FF0E);
        bus_read(8'h08, 32'h0000_FF0E, "R6 out read");

        // R11 unmapped offsets
        bus_write(8'h04, 32'hDEAD_BEEF);
        bus_read(8'h04, 32'h0, "R11 unmapped 04");
        bus_read(8'h18, 32'h0, "R11 unmapped 18");
        chk("R11 unmapped write no effect", {pin_oe, pin_out}, 32'hA55A_FF0E);

        // R10 individual requests, R7 pin state
        set_pins(16'h00A5);
        chk("R10 irq_pin", {24'h0, irq_pin}, 32'h0000_00A5);
        chk("R9 shared idle", {31'h0, irq_shared}, 32'h0);
        bus_read(8'h0C, 32'h0000_00A5, "R7 pin state");

        // R9 shared line with enables
        set_pins(16'hFF00);
        chk("R9 no enables", {31'h0, irq_shared}, 32'h0);
        set_pins(16'h0000);
        bus_write(8'h10, 32'h0000_FF04);
        bus_read(8'h10, 32'h0000_0004, "R8 ien width");
        set_pins(16'h0400);
        chk("R8 bit2 -> pin10", {31'h0, irq_shared}, 32'h1);
        chk("R10 no ien effect", {24'h0, irq_pin}, 32'h0);
        set_pins(16'h0800);
        chk("R9 pin11 disabled", {31'h0, irq_shared}, 32'h0);
        set_pins(16'h0400);
        chk("R9 reassert", {31'h0, irq_shared}, 32'h1);
        set_pins(16'h0000);
        chk("R9 level drop", {31'h0, irq_shared}, 32'h0);

        // R7 synchroniser latency
        @(negedge clk);
        pin_in = 16'h1234;
        @(negedge clk);
        chk("R7 one edge", {24'h0, irq_pin}, 32'h0);
        @(negedge clk);
        chk("R7 two edges", {24'h0, irq_pin}, 32'h0000_0034);
        chk("R9 pins 9,12 disabled", {31'h0, irq_shared}, 32'h0);

        // R3 re-entering soft reset clears state
        bus_write(8'h14, 32'h2);
        @(negedge clk);
        chk("R3 oe cleared", {16'h0, pin_oe}, 32'h0);
        chk("R3 out cleared", {16'h0, pin_out}, 32'h0);
        chk("R3 irq cleared", {23'h0, irq_shared, irq_pin}, 32'h0);
        bus_read(8'h14, 32'h2, "R2 ctrl 2");
        bus_read(8'h10, 32'h0, "R3 ien cleared");
        bus_read(8'h0C, 32'h0, "R3 pin state cleared");
        bus_write(8'h14, 32'h1);
        bus_read(8'h00, 32'h0, "R3 dir after restart");
        repeat (2) @(negedge clk);
        bus_read(8'h0C, 32'h0000_1234, "R7 pin state after restart");

        // R11 read data holds between reads
        repeat (3) @(negedge clk);
        chk("R11 rdata hold", bus_rdata, 32'h0000_1234);

        repeat (2) @(negedge clk);
        if (exp_q.size() != 0) chk("R11 pending reads", exp_q.size(), 0);
        finish_run();
    end
endmodule